// File: doc/BRIEF.md
# DMA Remap Mode Gate

This block stands at the entry of a DMA remapping unit. Each incoming device request carries a source ID, an I/O virtual address, a read flag and two attribute bits. The block captures the request together with the two-bit translation-mode field and two capability bits, and decides whether the request may go on to address translation.

A request the block turns away has one of two outcomes. It may set a sticky target-abort flag. Or it may produce a 128-bit primary fault record with an 8-bit reason code. The record is offered on a valid/ready port and held until the consumer accepts it.

The controller is a three-state machine:
- **IDLE** accepts a request (`req_valid` while `req_ready`) and moves to **EVAL**.
- **EVAL** lasts exactly one cycle and presents the verdict. It moves to **PUSH** when a fault record is due, and back to **IDLE** otherwise (pass, or target abort).
- **PUSH** offers the record and returns to **IDLE** on the cycle `flt_ready` is high.

Top module: `dma_mode_gate`

## Requirements
- R1: The request type is write (code 0) when `req_read` is 0 and read (code 2) when it is 1. Type bit 0 is placed at record bit 88 and type bit 1 at record bit 89.
- R2: With mode 2'b00 (legacy) the request passes (`res_pass`=1), no fault record is offered and the abort flag is unchanged.
- R3: With mode 2'b01 (scalable) the request passes if `cap_scalable` is 1. Otherwise it fails and a record with reason 8'h32 is offered.
- R4: With mode 2'b11 (abort) and `cap_abort` 1, the request fails, `abort_flag` becomes 1, and no record is offered.
- R5: With mode 2'b11 and `cap_abort` 0, the request fails and a record with reason 8'h30 is offered.
- R6: With mode 2'b10 (reserved) the request fails and a record with reason 8'h31 is offered, whatever the capability bits are.
- R7: Record layout:
  - bits [63:0] hold the request address with bits [11:0] cleared;
  - bits [79:64] hold the source ID;
  - bits [87:80] hold the reason code, which equals `flt_reason`;
  - bits [127:92] are zero.
- R8: Attribute bit 0 (supervisor privilege) appears at record bit 90 and attribute bit 1 (execute) at record bit 91.
- R9: `res_valid` is a single-cycle pulse in the cycle after the request is accepted. `res_pass` is meaningful with it.
- R10: `flt_valid` rises in the cycle after the verdict. While `flt_ready` is low, the record and reason hold stable. `req_ready` stays low from acceptance until the record is taken.
- R11: `abort_flag` is sticky. A one-cycle `abort_clr` clears it, and a set in the same cycle as a clear wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_sid | input | 16 | Source ID of the requester |
| req_addr | input | ADDR_W | I/O virtual address |
| req_read | input | 1 | 1 = read, 0 = write |
| req_attr | input | 2 | bit0 supervisor, bit1 execute |
| mode | input | 2 | Translation-mode field |
| cap_scalable | input | 1 | Scalable mode supported |
| cap_abort | input | 1 | Abort mode supported |
| res_valid | output | 1 | Verdict pulse |
| res_pass | output | 1 | Request may be translated |
| flt_valid | output | 1 | Fault record offered |
| flt_ready | input | 1 | Consumer takes the record |
| flt_record | output | 128 | Primary fault record |
| flt_reason | output | 8 | Fault reason code |
| abort_flag | output | 1 | Sticky target-abort status |
| abort_clr | input | 1 | Write-one-to-clear for abort_flag |

## Verification
The assertions check the following on every cycle:
- the verdict is a single-cycle pulse;
- the record is held while stalled;
- the reason is always one of the three legal codes and matches the record field;
- the page offset bits of the record are zero;
- the abort flag is sticky;
- a passing verdict is never followed by a record.

Only the bench's scenarios can show that each mode and capability combination picks the right outcome. The same holds for the source ID, type and attribute bits landing in the right record positions, and for the clear and set-priority behaviour of the abort flag.

// File: rtl/dmg_pkg.sv
package dmg_pkg;
    localparam int REC_W = 128;
    localparam int RSN_W = 8;

    typedef enum logic [1:0] {
        MODE_LEGACY   = 2'b00,
        MODE_SCALABLE = 2'b01,
        MODE_RSVD     = 2'b10,
        MODE_ABORT    = 2'b11
    } tmode_e;

    typedef enum logic [1:0] {
        RQ_WRITE  = 2'd0,
        RQ_PAGE   = 2'd1,
        RQ_READ   = 2'd2,
        RQ_ATOMIC = 2'd3
    } rqtype_e;

    localparam logic [RSN_W-1:0] RSN_ABORT_NOCAP = 8'h30;
    localparam logic [RSN_W-1:0] RSN_MODE_RSVD   = 8'h31;
    localparam logic [RSN_W-1:0] RSN_SCAL_NOCAP  = 8'h32;

    typedef struct packed {
        logic             pass;
        logic             abort;
        logic             fault;
        logic [RSN_W-1:0] reason;
    } verdict_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EVAL = 2'd1,
        ST_PUSH = 2'd2
    } state_e;
endpackage

// File: rtl/dmg_mode_decode.sv
module dmg_mode_decode
    import dmg_pkg::*;
(
    input  tmode_e   mode_i,
    input  logic     cap_scalable_i,
    input  logic     cap_abort_i,
    output verdict_t verdict_o
);
    always_comb begin
        verdict_o = '{pass: 1'b0, abort: 1'b0, fault: 1'b0, reason: '0};
        unique case (mode_i)
            MODE_LEGACY: begin
                verdict_o.pass = 1'b1;
            end
            MODE_SCALABLE: begin
                if (cap_scalable_i) begin
                    verdict_o.pass = 1'b1;
                end else begin
                    verdict_o.fault  = 1'b1;
                    verdict_o.reason = RSN_SCAL_NOCAP;
                end
            end
            MODE_ABORT: begin
                if (cap_abort_i) begin
                    verdict_o.abort = 1'b1;
                end else begin
                    verdict_o.fault  = 1'b1;
                    verdict_o.reason = RSN_ABORT_NOCAP;
                end
            end
            MODE_RSVD: begin
                verdict_o.fault  = 1'b1;
                verdict_o.reason = RSN_MODE_RSVD;
            end
            default: begin
                verdict_o.fault  = 1'b1;
                verdict_o.reason = RSN_MODE_RSVD;
            end
        endcase
    end
endmodule

// File: rtl/dmg_record_pack.sv
module dmg_record_pack
    import dmg_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int SID_W      = 16,
    parameter int PAGE_SHIFT = 12
) (
    input  logic [SID_W-1:0]  sid_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              read_i,
    input  logic [1:0]        attr_i,
    input  logic [RSN_W-1:0]  reason_i,
    output logic [REC_W-1:0]  record_o
);
    localparam int HALF_W = REC_W / 2;
    localparam int PAD_W  = HALF_W - SID_W - RSN_W - 4;

    rqtype_e            rtype;
    logic [HALF_W-1:0]  lo_half;
    logic [HALF_W-1:0]  hi_half;

    always_comb begin
        rtype = read_i ? RQ_READ : RQ_WRITE;

        lo_half                   = '0;
        lo_half[ADDR_W-1:0]       = addr_i;
        lo_half[PAGE_SHIFT-1:0]   = '0;

        hi_half = {{PAD_W{1'b0}}, attr_i[1], attr_i[0], rtype[1], rtype[0],
                   reason_i, sid_i};

        record_o = {hi_half, lo_half};
    end
endmodule

// File: rtl/dma_mode_gate.sv
module dma_mode_gate
    import dmg_pkg::*;
#(
    parameter int ADDR_W     = 64,
    parameter int SID_W      = 16,
    parameter int PAGE_SHIFT = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [SID_W-1:0]  req_sid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_read,
    input  logic [1:0]        req_attr,
    input  logic [1:0]        mode,
    input  logic              cap_scalable,
    input  logic              cap_abort,
    output logic              res_valid,
    output logic              res_pass,
    output logic              flt_valid,
    input  logic              flt_ready,
    output logic [127:0]      flt_record,
    output logic [7:0]        flt_reason,
    output logic              abort_flag,
    input  logic              abort_clr
);
    state_e             state_q, state_nx;
    logic [SID_W-1:0]   sid_q;
    logic [ADDR_W-1:0]  addr_q;
    logic               read_q;
    logic [1:0]         attr_q;
    tmode_e             mode_q;
    logic               caps_q, capa_q;
    logic               accept;
    verdict_t           verdict;
    logic [REC_W-1:0]   record;
    logic               abort_q;

    assign accept = req_valid && (state_q == ST_IDLE);

    dmg_mode_decode i_decode (
        .mode_i         (mode_q),
        .cap_scalable_i (caps_q),
        .cap_abort_i    (capa_q),
        .verdict_o      (verdict)
    );

    dmg_record_pack #(
        .ADDR_W     (ADDR_W),
        .SID_W      (SID_W),
        .PAGE_SHIFT (PAGE_SHIFT)
    ) i_pack (
        .sid_i    (sid_q),
        .addr_i   (addr_q),
        .read_i   (read_q),
        .attr_i   (attr_q),
        .reason_i (verdict.reason),
        .record_o (record)
    );

    // next-state logic
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_IDLE: if (accept)        state_nx = ST_EVAL;
            ST_EVAL: state_nx = verdict.fault ? ST_PUSH : ST_IDLE;
            ST_PUSH: if (flt_ready)     state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_nx;
    end

    // request capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sid_q  <= '0;
            addr_q <= '0;
            read_q <= 1'b0;
            attr_q <= '0;
            mode_q <= MODE_LEGACY;
            caps_q <= 1'b0;
            capa_q <= 1'b0;
        end else if (accept) begin
            sid_q  <= req_sid;
            addr_q <= req_addr;
            read_q <= req_read;
            attr_q <= req_attr;
            mode_q <= tmode_e'(mode);
            caps_q <= cap_scalable;
            capa_q <= cap_abort;
        end
    end

    // sticky abort status, set wins over clear
    always_ff @(posedge clk) begin
        if (!rst_n)                                   abort_q <= 1'b0;
        else if (state_q == ST_EVAL && verdict.abort) abort_q <= 1'b1;
        else if (abort_clr)                           abort_q <= 1'b0;
    end

    // outputs
    always_comb begin
        req_ready  = (state_q == ST_IDLE);
        res_valid  = (state_q == ST_EVAL);
        res_pass   = (state_q == ST_EVAL) && verdict.pass;
        flt_valid  = (state_q == ST_PUSH);
        flt_record = record;
        flt_reason = verdict.reason;
        abort_flag = abort_q;
    end
endmodule

// File: rtl/dmg_checker.sv
module dmg_checker (
    input logic         clk,
    input logic         rst_n,
    input logic         req_ready,
    input logic         res_valid,
    input logic         res_pass,
    input logic         flt_valid,
    input logic         flt_ready,
    input logic [127:0] flt_record,
    input logic [7:0]   flt_reason,
    input logic         abort_flag,
    input logic         abort_clr
);
    // R9: verdict lasts one cycle
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);

    // R10: record held while stalled
    a_r10_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (flt_valid && !flt_ready) |=> (flt_valid && $stable(flt_record) && $stable(flt_reason)));

    // R10: no new request while a record is pending
    a_r10_busy: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> !req_ready);

    // R7: legal reason matching the record field
    a_r7_reason_code: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> ((flt_reason == 8'h30 || flt_reason == 8'h31 || flt_reason == 8'h32)
                       && flt_record[87:80] == flt_reason));

    // R7: page offset cleared, upper pad zero
    a_r7_layout: assert property (@(posedge clk) disable iff (!rst_n)
        flt_valid |-> (flt_record[11:0] == 12'h000 && flt_record[127:92] == '0));

    // R2: a passing verdict is not followed by a record
    a_r2_pass_no_record: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_pass) |=> !flt_valid);

    // R11: abort flag is sticky without a clear
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (abort_flag && !abort_clr) |=> abort_flag);
endmodule

bind dma_mode_gate dmg_checker i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_ready  (req_ready),
    .res_valid  (res_valid),
    .res_pass   (res_pass),
    .flt_valid  (flt_valid),
    .flt_ready  (flt_ready),
    .flt_record (flt_record),
    .flt_reason (flt_reason),
    .abort_flag (abort_flag),
    .abort_clr  (abort_clr)
);

// File: tb/test_dma_mode_gate.sv
`timescale 1ns/1ps
module test_dma_mode_gate;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [15:0]  req_sid = '0;
    logic [63:0]  req_addr = '0;
    logic         req_read = 1'b0;
    logic [1:0]   req_attr = '0;
    logic [1:0]   mode = '0;
    logic         cap_scalable = 1'b0;
    logic         cap_abort = 1'b0;
    logic         res_valid, res_pass, flt_valid;
    logic         flt_ready = 1'b0;
    logic [127:0] flt_record;
    logic [7:0]   flt_reason;
    logic         abort_flag;
    logic         abort_clr = 1'b0;

    int checks = 0;
    int errors = 0;
    logic model_abort = 1'b0;

    always #4 clk = ~clk;

    dma_mode_gate i_dma_mode_gate (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_sid(req_sid), .req_addr(req_addr), .req_read(req_read), .req_attr(req_attr),
        .mode(mode), .cap_scalable(cap_scalable), .cap_abort(cap_abort),
        .res_valid(res_valid), .res_pass(res_pass), .flt_valid(flt_valid),
        .flt_ready(flt_ready), .flt_record(flt_record), .flt_reason(flt_reason),
        .abort_flag(abort_flag), .abort_clr(abort_clr)
    );

    task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected outcome: {pass, abort, fault, reason}
    function automatic logic [10:0] exp_verdict(input logic [1:0] m, input logic cs, input logic ca);
        case (m)
            2'b00:   return {3'b100, 8'h00};
            2'b01:   return cs ? {3'b100, 8'h00} : {3'b001, 8'h32};
            2'b11:   return ca ? {3'b010, 8'h00} : {3'b001, 8'h30};
            default: return {3'b001, 8'h31};
        endcase
    endfunction

    function automatic logic [127:0] exp_record(input logic [15:0] sid, input logic [63:0] a,
                                                input logic rd, input logic [1:0] at,
                                                input logic [7:0] rsn);
        logic [1:0] ty;
        ty = rd ? 2'd2 : 2'd0;
        return {36'b0, at[1], at[0], ty[1], ty[0], rsn, sid, a[63:12], 12'h000};
    endfunction

    task automatic run_req(input logic [15:0] sid, input logic [63:0] a, input logic rd,
                           input logic [1:0] at, input logic [1:0] m, input logic cs,
                           input logic ca, input int stall);
        logic [10:0]  v;
        logic [127:0] er;
        string        rtag;
        v  = exp_verdict(m, cs, ca);
        er = exp_record(sid, a, rd, at, v[7:0]);
        case (m)
            2'b00:   rtag = "R2";
            2'b01:   rtag = "R3";
            2'b11:   rtag = ca ? "R4" : "R5";
            default: rtag = "R6";
        endcase
        @(negedge clk);
        req_sid = sid; req_addr = a; req_read = rd; req_attr = at;
        mode = m; cap_scalable = cs; cap_abort = ca; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        req_sid = ~sid; req_addr = ~a; mode = ~m;
        chk("R9 res_valid pulse", res_valid, 1'b1);
        chk({rtag, " res_pass"}, res_pass, v[10]);
        chk("R10 busy after accept", req_ready, 1'b0);
        if (v[9]) model_abort = 1'b1;
        @(negedge clk);
        chk("R9 res_valid drops", res_valid, 1'b0);
        chk({rtag, " abort_flag"}, abort_flag, model_abort);
        if (v[8]) begin
            chk({rtag, " flt_valid"}, flt_valid, 1'b1);
            chk({rtag, " reason"}, flt_reason, v[7:0]);
            chk("R7 record layout", flt_record[87:0], er[87:0]);
            chk("R1 type bits", flt_record[89:88], er[89:88]);
            chk("R8 attr bits", flt_record[91:90], er[91:90]);
            chk("R7 pad zero", flt_record[127:92], er[127:92]);
            for (int i = 0; i < stall; i++) begin
                @(negedge clk);
                chk("R10 held while stalled", {flt_valid, flt_record}, {1'b1, er});
                chk("R10 busy while stalled", req_ready, 1'b0);
            end
            flt_ready = 1'b1;
            @(negedge clk);
            flt_ready = 1'b0;
            chk("R10 released", flt_valid, 1'b0);
            chk("R10 ready again", req_ready, 1'b1);
        end else begin
            chk({rtag, " no record"}, flt_valid, 1'b0);
            chk("R10 ready after verdict", req_ready, 1'b1);
        end
    endtask

    task automatic pulse_clr(input int tag_r11);
        @(negedge clk);
        abort_clr = 1'b1;
        @(negedge clk);
        abort_clr = 1'b0;
        model_abort = 1'b0;
        chk("R11 cleared", abort_flag, 1'b0);
        if (tag_r11 != 0) chk("R11 stays cleared", abort_flag, model_abort);
    endtask

    initial begin
        repeat (1000000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int unused;
        unused = $urandom(32'd20251);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset res_valid", res_valid, 1'b0);
        chk("R10 reset flt_valid", flt_valid, 1'b0);
        chk("R10 reset req_ready", req_ready, 1'b1);
        chk("R11 reset abort_flag", abort_flag, 1'b0);

        // directed
        run_req(16'hA5C3, 64'h1234_5678_9ABC_DFFF, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 0);
        run_req(16'h0102, 64'h0000_0000_0000_1FFF, 1'b1, 2'b11, 2'b01, 1'b1, 1'b0, 0);
        run_req(16'hBEEF, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1, 2'b01, 2'b01, 1'b0, 1'b1, 3);
        run_req(16'h0001, 64'h0000_0000_DEAD_B123, 1'b0, 2'b10, 2'b11, 1'b1, 1'b0, 1);
        run_req(16'hFFFF, 64'h8000_0000_0000_0FFF, 1'b1, 2'b00, 2'b10, 1'b1, 1'b1, 2);
        run_req(16'h7777, 64'h0000_0000_0000_4000, 1'b0, 2'b11, 2'b10, 1'b0, 1'b0, 0);
        run_req(16'h1111, 64'h0000_0000_0000_5000, 1'b0, 2'b00, 2'b11, 1'b0, 1'b1, 0);
        run_req(16'h2222, 64'h0000_0000_0000_6000, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 0);
        pulse_clr(1);
        // set wins over a clear in the same cycle
        fork
            run_req(16'h3333, 64'h7000, 1'b0, 2'b00, 2'b11, 1'b0, 1'b1, 0);
            begin
                @(negedge clk); @(negedge clk);
                abort_clr = 1'b1;
                @(negedge clk);
                abort_clr = 1'b0;
            end
        join
        chk("R11 set wins over clear", abort_flag, 1'b1);
        pulse_clr(0);

        // random
        for (int n = 0; n < 400; n++) begin
            run_req(16'($urandom), {$urandom, $urandom}, 1'($urandom), 2'($urandom),
                    2'($urandom), 1'($urandom), 1'($urandom), int'($urandom % 4));
            if ($urandom % 8 == 0) pulse_clr(0);
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule